// File: doc/BRIEF.md
# Auto-increment prefetching ROM port

This block is a byte-wide read-only memory that a host reaches only through an internal 16-bit address counter. The host writes the counter as two bytes, high byte first. After the second byte it may read data bytes in sequence. Each data read returns a byte that was fetched in advance into a one-byte buffer. The block then fetches the next byte and advances the counter. Reading the counter back is destructive, and because of the prefetch the value returned is one higher than the value loaded.

The counter splits into a 3-bit identity prefix in the top bits and a 13-bit offset. Up to eight instances with different fixed identities can share one bus. All of them track the same counter value and do the same internal work. Only the instance whose identity equals the prefix enables its read data onto the bus. Each instance holds 6 KiB of content, and offsets at or above 6144 read as zero.

Every access starts on the rising edge of a select input. A READY output falls in that same cycle and rises again when the access has finished. A separate enable output lets several instances share the READY wire as a wired pull-down.

Top module: `seq_rom_port`

## Requirements
- R1: After reset, `ready_o` is 1, `ready_oe_o` is 0 and `rdata_oe_o` is 0.
- R2: A rising edge of `sel_i` pulls `ready_o` low in the same cycle. `ready_o` returns high LAT clock edges after the first edge at which the select is seen, where LAT is 3 by default. Holding `sel_i` high afterwards starts no new access.
- R3: `op_i` encodes the access as {counter_target, read}. The value 2 writes the counter. Each counter write shifts the counter left by 8 and puts `wdata_i` in the low byte. Every second counter write fetches the byte at the new address into the buffer and increments the counter.
- R4: A data read (`op_i`=1) returns the buffered byte, then loads the byte at the counter into the buffer and increments the counter.
- R5: A counter read (`op_i`=3) returns the counter's high byte and leaves the counter holding its old low byte in both halves. After a two-byte load of address A, two counter reads return the high and low bytes of A+1.
- R6: A data write (`op_i`=0) changes neither the counter nor the buffer.
- R7: `rdata_oe_o` is 1 only while `sel_i` is held after a completed read, and only when the counter's prefix at the start of that access equals the instance identity ID (3 by default).
- R8: An increment wraps the 13-bit offset from 0x1FFF to 0x0000 and leaves the 3-bit prefix unchanged.
- R9: The byte stored at offset `o` is o[7:0] XOR o[12:8] XOR (ID<<5). Every offset from 6144 upward reads 0x00.
- R10: `ready_oe_o` is 1 exactly when `ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Select; its rising edge starts an access |
| op_i | input | 2 | Access code {counter_target, read} |
| wdata_i | input | 8 | Byte written to the counter |
| rdata_o | output | 8 | Read byte |
| rdata_oe_o | output | 1 | Read-data drive enable |
| ready_o | output | 1 | High when idle or finished |
| ready_oe_o | output | 1 | Pull-down enable for a shared READY wire |

## Verification
The bench loads an address and reads it back. A design without the load-time prefetch returns the loaded value instead of that value plus one, and a non-destructive counter read returns the high byte twice. It walks across the 6 KiB boundary and across the top of the 13-bit offset. A design with a wrong bound returns nonzero data above offset 6143, and a design with a full 16-bit increment moves the prefix into a foreign identity. It also holds select after an access ends and places the counter in another instance's segment. A level-triggered select would stall READY again, and a missing identity check would drive the bus for data that belongs to another instance.

// File: rtl/seq_rom_pkg.sv
package seq_rom_pkg;
  localparam int ADDR_W = 16;
  localparam int ID_W   = 3;
  localparam int OFF_W  = ADDR_W - ID_W;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    OP_DATA_WR = 2'd0,
    OP_DATA_RD = 2'd1,
    OP_ADDR_WR = 2'd2,
    OP_ADDR_RD = 2'd3
  } op_e;
endpackage

// File: rtl/seq_rom_array.sv
module seq_rom_array
  import seq_rom_pkg::*;
#(
  parameter logic [ID_W-1:0] ID         = 3'd3,
  parameter int              USED_BYTES = 6144
) (
  input  logic [OFF_W-1:0]  off_i,
  output logic [DATA_W-1:0] byte_o
);
  localparam int HI_W = OFF_W - DATA_W;
  localparam logic [DATA_W-1:0] ID_MIX = {ID, {(DATA_W-ID_W){1'b0}}};

  logic [DATA_W-1:0] hi_mix;
  assign hi_mix = {{(DATA_W-HI_W){1'b0}}, off_i[OFF_W-1:DATA_W]};

  always_comb begin
    if (int'(off_i) < USED_BYTES) byte_o = off_i[DATA_W-1:0] ^ hi_mix ^ ID_MIX;
    else                          byte_o = '0;
  end
endmodule

// File: rtl/seq_rom_ctrl.sv
module seq_rom_ctrl
  import seq_rom_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              match_i,
  output logic              ready_o,
  output logic              done_o,
  output op_e               op_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic              match_q_o,
  output logic              drive_o
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          sel_q, busy_q, start;
  logic [CW-1:0] cnt_q;

  assign start   = sel_i && !sel_q && !busy_q;
  assign done_o  = busy_q && (cnt_q == '0);
  assign ready_o = !(start || busy_q);
  assign drive_o = sel_i && sel_q && !busy_q && op_q_o[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= 1'b0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      op_q_o    <= OP_DATA_WR;
      wdata_q_o <= '0;
      match_q_o <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (start) begin
        busy_q    <= 1'b1;
        cnt_q     <= CW'(LAT - 1);
        op_q_o    <= op_i;
        wdata_q_o <= wdata_i;
        match_q_o <= match_i;
      end else if (done_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r2_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_o |=> busy_q);
  a_r2_no_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && sel_q && !busy_q |=> !busy_q);
  a_r7_drive_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> ready_o);
endmodule

// File: rtl/seq_rom_addr.sv
module seq_rom_addr
  import seq_rom_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] fetch_byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFF_W-1:0]  fetch_off_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_q, shift_addr, fetch_addr, inc_addr;
  logic [DATA_W-1:0] buf_q;
  logic              tog_q;

  assign shift_addr  = {addr_q[DATA_W-1:0], wdata_i};
  assign fetch_addr  = (op_i == OP_ADDR_WR) ? shift_addr : addr_q;
  // offset wraps inside its segment, prefix kept
  assign inc_addr    = {fetch_addr[ADDR_W-1:OFF_W], fetch_addr[OFF_W-1:0] + 1'b1};
  assign fetch_off_o = fetch_addr[OFF_W-1:0];
  assign addr_o      = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      buf_q   <= '0;
      tog_q   <= 1'b0;
      rdata_o <= '0;
    end else if (done_i) begin
      unique case (op_i)
        OP_DATA_RD: begin
          rdata_o <= buf_q;
          buf_q   <= fetch_byte_i;
          addr_q  <= inc_addr;
        end
        OP_ADDR_RD: begin
          rdata_o <= addr_q[ADDR_W-1:DATA_W];
          addr_q  <= {addr_q[DATA_W-1:0], addr_q[DATA_W-1:0]};
        end
        OP_ADDR_WR: begin
          tog_q <= !tog_q;
          if (tog_q) begin
            buf_q  <= fetch_byte_i;
            addr_q <= inc_addr;
          end else begin
            addr_q <= shift_addr;
          end
        end
        default: ;
      endcase
    end
  end

  a_r6_data_write_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && op_i == OP_DATA_WR |=> $stable(addr_q) && $stable(buf_q));
  a_r5_destructive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && op_i == OP_ADDR_RD |=> addr_q[ADDR_W-1:DATA_W] == addr_q[DATA_W-1:0]);
  a_r8_prefix_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && op_i == OP_DATA_RD |=> addr_q[ADDR_W-1:OFF_W] == $past(addr_q[ADDR_W-1:OFF_W]));
  a_r4_buffer_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && op_i == OP_DATA_RD |=> rdata_o == $past(buf_q));
endmodule

// File: rtl/seq_rom_port.sv
module seq_rom_port
  import seq_rom_pkg::*;
#(
  parameter logic [2:0] ID         = 3'd3,
  parameter int         LAT        = 3,
  parameter int         USED_BYTES = 6144
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic [1:0] op_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       rdata_oe_o,
  output logic       ready_o,
  output logic       ready_oe_o
);
  op_e               op_in, op_q;
  logic [DATA_W-1:0] wdata_q, fetch_byte;
  logic [ADDR_W-1:0] addr;
  logic [OFF_W-1:0]  fetch_off;
  logic              done, match_q, drive, match_now;

  assign op_in     = op_e'(op_i);
  assign match_now = (addr[ADDR_W-1:OFF_W] == ID);

  seq_rom_ctrl #(.LAT(LAT)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .op_i     (op_in),
    .wdata_i  (wdata_i),
    .match_i  (match_now),
    .ready_o  (ready_o),
    .done_o   (done),
    .op_q_o   (op_q),
    .wdata_q_o(wdata_q),
    .match_q_o(match_q),
    .drive_o  (drive)
  );

  seq_rom_addr u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .op_i        (op_q),
    .wdata_i     (wdata_q),
    .fetch_byte_i(fetch_byte),
    .addr_o      (addr),
    .fetch_off_o (fetch_off),
    .rdata_o     (rdata_o)
  );

  seq_rom_array #(.ID(ID), .USED_BYTES(USED_BYTES)) u_array (
    .off_i (fetch_off),
    .byte_o(fetch_byte)
  );

  assign rdata_oe_o = drive && match_q;
  assign ready_oe_o = !ready_o;

  a_r10_pulldown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_oe_o != ready_o);
  a_r7_oe_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> sel_i);
endmodule

// File: tb/seq_rom_port_tb.sv
`timescale 1ns/1ps
module seq_rom_port_tb;
  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rdata;
  logic       rdata_oe, ready, ready_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #2 clk = !clk;

  seq_rom_port #(.ID(3'd3), .LAT(LAT), .USED_BYTES(6144)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .op_i(op), .wdata_i(wd),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe), .ready_o(ready), .ready_oe_o(ready_oe)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one access; returns cycles to ready, then oe and data while select held
  task automatic access(input logic [1:0] c, input logic [7:0] d,
                        output int cyc, output logic oe, output logic [7:0] rd,
                        input int hold = 0);
    @(negedge clk);
    op = c; wd = d; sel = 1'b1;
    #0.5;
    check("R2 ready low at select", ready, 0);
    check("R10 pulldown while busy", ready_oe, 1);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!ready && cyc < 50);
    oe = rdata_oe; rd = rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R2 held select no retrigger", ready, 1);
    end
    sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input logic [15:0] a);
    int c; logic o; logic [7:0] r;
    access(2'd2, a[15:8], c, o, r);
    access(2'd2, a[7:0], c, o, r);
  endtask

  task automatic data_rd(input string req, input int exp);
    int c; logic o; logic [7:0] r;
    access(2'd1, 8'h00, c, o, r);
    check({req, " oe"}, o, 1);
    check(req, r, exp);
  endtask

  // {op, wdata, expected oe, expected rdata}
  localparam logic [18:0] VEC [8] = '{
    {2'd2, 8'h61, 1'b0, 8'h00},
    {2'd2, 8'h23, 1'b0, 8'h00},
    {2'd1, 8'h00, 1'b1, 8'h42},
    {2'd1, 8'h00, 1'b1, 8'h45},
    {2'd0, 8'hFF, 1'b0, 8'h00},
    {2'd1, 8'h00, 1'b1, 8'h44},
    {2'd3, 8'h00, 1'b1, 8'h61},
    {2'd3, 8'h00, 1'b0, 8'h00}
  };

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int c; logic o; logic [7:0] r;
    #1;
    check("R1 reset ready", ready, 1);
    check("R1 reset ready_oe", ready_oe, 0);
    check("R1 reset rdata_oe", rdata_oe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", ready, 1);

    // table walk: R3 load, R4 reads, R6 data write ignored, R5/R7 counter reads
    foreach (VEC[i]) begin
      access(VEC[i][18:17], VEC[i][16:9], c, o, r, (i == 0) ? 4 : 0);
      check("R2 latency", c, LAT + 1);
      check("R7 drive enable", o, VEC[i][8]);
      if (VEC[i][8]) check("R4/R5 table data", r, VEC[i][7:0]);
    end
    check("R10 idle pulldown off", ready_oe, 0);

    // R5: readback is loaded value plus one, destructive
    load(16'h6000);
    access(2'd3, 8'h00, c, o, r);
    check("R5 high byte", r, 8'h60);
    access(2'd3, 8'h00, c, o, r);
    check("R5 low byte plus one", r, 8'h01);

    // R9: last populated byte and first empty one
    load(16'h77FF);
    data_rd("R9 offset 6143", 8'h88);
    data_rd("R9 offset 6144 zero", 8'h00);

    // R8: wrap at top of segment keeps prefix
    load(16'h7FFF);
    data_rd("R9 offset 0x1FFF zero", 8'h00);
    data_rd("R8 wrapped to offset 0", 8'h60);
    access(2'd3, 8'h00, c, o, r);
    check("R8 prefix kept", r, 8'h60);

    // R6: data write between reads leaves stream intact
    load(16'h6010);
    access(2'd0, 8'hAA, c, o, r);
    check("R6 write no drive", o, 0);
    data_rd("R6 buffer unchanged", 8'h70);
    data_rd("R6 counter unchanged", 8'h71);

    // R7: foreign segment never drives
    load(16'h0010);
    access(2'd1, 8'h00, c, o, r);
    check("R7 foreign prefix oe", o, 0);
    check("R7 no oe after release", rdata_oe, 0);

    finish_run();
  end
endmodule